// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD byte registers: seconds, minutes, hours, day of week, date, month and year. A one-second enable pulse from an external prescaler advances the registers once per pulse. Carries pass from seconds up through the year. The hour byte can hold either a 24-hour value or a 12-hour value with a PM flag, and the mode is selected by a bit inside that same byte. Month lengths, including February in leap years, set the point where the date rolls over. A halt bit in the seconds byte freezes timekeeping.

A host loads any single register through a byte-wide write port. A write to the seconds byte is reported on a one-cycle strobe, so the prescaler can restart its count. Reads never come from the running registers. A capture strobe, which the host raises at the start of each bus transaction, copies all seven registers into a shadow bank, and a byte-wide read port then selects from that bank. A multi-byte read therefore sees one consistent instant while the counters keep running.

Top module: `rtc_calendar_core`

## Requirements
- R1: On each advancing tick the seconds field (bits 6:0) counts 00..59 in BCD. From 59 it returns to 00 and advances minutes, which count 00..59 the same way and carry into the hour field from 59.
- R2: While bit 7 of the seconds byte is 1, ticks change no register, and the bit itself reads back as written. While it is 0, ticks advance the clock.
- R3: With hour bit 6 = 0 (24-hour mode), bits 5:0 hold BCD hours 00..23. An hour carry from 23 gives 00 and one day carry, and from 09 or 19 it gives 10 or 20.
- R4: With hour bit 6 = 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01..12. An hour carry steps 11→12 and flips PM, and steps 12→01 with PM unchanged. A day carry happens only on 11 PM → 12 AM.
- R5: On every day carry the day-of-week byte steps 1..7, and from 7 it wraps to 1.
- R6: On a day carry the date returns to 01 and the month advances once the date has reached the month's last day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. For month 02 it is 29 when the BCD year is a multiple of 4 (00 included) and 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Bits with no meaning read back as 0. The masks per index are 0:FF, 1:7F, 2:7F, 3:07, 4:3F, 5:1F, 6:FF. Index 7 reads 0 and ignores writes.
- R8: When snap_req is high at a clock edge, the shadow bank takes the register values from before that edge. rd_data shows shadow[rd_idx] combinationally, and it does not follow later ticks until the next capture.
- R9: wr_en loads wr_data, masked, into the register at wr_idx at the clock edge. The index map is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A tick in a cycle with wr_en high is dropped.
- R10: sec_written is high for exactly the one cycle after an edge where wr_en was high with wr_idx = 0, and low otherwise.
- R11: Synchronous reset sets seconds 00 (running), minutes 00, hours 00 in 24-hour mode, day of week 01, date 01, month 01 and year 00, both in the live registers and in the shadow bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 8 | Write byte |
| snap_req | input | 1 | Capture strobe for the shadow bank |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 8 | Shadow bank byte at rd_idx |
| sec_written | output | 1 | One-cycle report of a seconds write |

## Verification
The counting properties assume that every value the host writes is a legal BCD entry for its field. Under that assumption the carries and wraps are well defined; an illogical date or hour entry has no defined successor. The stimulus therefore writes only in-range values: the rollover table, the 12-hour crossings and the leap-February cases. The only exception is the mask test, which writes all-ones bytes and overwrites them before any tick arrives. Ticks are applied only when no write is pending, except in the single case that tests write priority.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int REG_COUNT = 7;
    localparam int IDX_W     = 3;
    localparam int BYTE_W    = 8;

    typedef enum logic [IDX_W-1:0] {
        IX_SEC   = 3'd0,
        IX_MIN   = 3'd1,
        IX_HOUR  = 3'd2,
        IX_DOW   = 3'd3,
        IX_DATE  = 3'd4,
        IX_MONTH = 3'd5,
        IX_YEAR  = 3'd6,
        IX_NONE  = 3'd7
    } reg_ix_e;

    // Bits that carry meaning in each register
    function automatic logic [BYTE_W-1:0] field_mask(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            6:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(input int i);
        case (i)
            3, 4, 5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Two-digit BCD increment without range wrap
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by four
    function automatic logic leap_year(input logic [7:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] last_date(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'h02:                      return leap_year(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_cal_pkg::*;
(
    input  logic [6:0] hour_in,
    output logic [7:0] hour_out,
    output logic       day_carry
);
    logic [4:0] h12;
    logic       pm;
    logic [7:0] inc12;
    logic [7:0] inc24;

    always_comb begin
        h12       = hour_in[4:0];
        pm        = hour_in[5];
        inc12     = bcd_inc({3'b000, h12});
        inc24     = bcd_inc({2'b00, hour_in[5:0]});
        day_carry = 1'b0;
        hour_out  = {1'b0, hour_in};
        if (hour_in[6]) begin
            if (h12 == 5'h12) begin
                hour_out = {2'b01, pm, 5'h01};
            end else if (h12 == 5'h11) begin
                hour_out  = {2'b01, ~pm, 5'h12};
                day_carry = pm;
            end else begin
                hour_out = {2'b01, pm, 5'b0} | (inc12 & 8'h1F);
            end
        end else begin
            if (hour_in[5:0] == 6'h23) begin
                hour_out  = 8'h00;
                day_carry = 1'b1;
            end else begin
                hour_out = inc24 & 8'h3F;
            end
        end
    end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
    import rtc_cal_pkg::*;
(
    input  logic [2:0] dow_in,
    input  logic [5:0] date_in,
    input  logic [4:0] month_in,
    input  logic [7:0] year_in,
    output logic [7:0] dow_out,
    output logic [7:0] date_out,
    output logic [7:0] month_out,
    output logic [7:0] year_out,
    output logic       month_roll
);
    logic [7:0] date_b;
    logic [7:0] month_b;
    logic       year_roll;

    always_comb begin
        date_b     = {2'b00, date_in};
        month_b    = {3'b000, month_in};
        dow_out    = (dow_in == 3'd7) ? 8'h01 : {5'b0, dow_in + 3'd1};
        month_roll = (date_b == last_date(month_b, year_in));
        date_out   = month_roll ? 8'h01 : bcd_inc(date_b);
        year_roll  = month_roll && (month_b == 8'h12);
        if (!month_roll)
            month_out = month_b;
        else if (month_b == 8'h12)
            month_out = 8'h01;
        else
            month_out = bcd_inc(month_b);
        if (!year_roll)
            year_out = year_in;
        else if (year_in == 8'h99)
            year_out = 8'h00;
        else
            year_out = bcd_inc(year_in);
    end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_cal_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          capture,
    input  logic [REG_COUNT*BYTE_W-1:0]   live_flat,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [BYTE_W-1:0]             rd_data
);
    logic [BYTE_W-1:0] shadow [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_shadow
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= reset_value(i);
            else if (capture)
                q <= live_flat[i*BYTE_W +: BYTE_W];
        end
        assign shadow[i] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < REG_COUNT; k++)
            if (rd_idx == IDX_W'(k))
                rd_data = shadow[k];
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(shadow[0]) && $stable(shadow[1]) && $stable(shadow[4])); // R8
    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        capture |=> shadow[0] == $past(live_flat[BYTE_W-1:0])); // R8
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        shadow[3][7:3] == 5'd0 && shadow[5][7:5] == 3'd0 && shadow[2][7] == 1'b0); // R7
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              snap_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              sec_written
);
    logic [BYTE_W-1:0]             cur [REG_COUNT];
    logic [BYTE_W-1:0]             nxt [REG_COUNT];
    logic [REG_COUNT*BYTE_W-1:0]   live_flat;

    logic       halted, advance;
    logic       sec_wrap, hour_adv, day_roll;
    logic [7:0] hr_next;
    logic       hr_carry;
    logic [7:0] dow_n, date_n, month_n, year_n;
    logic       month_roll;

    assign halted  = cur[IX_SEC][7];
    assign advance = tick_1hz && !halted && !wr_en;

    rtc_hour_step u_hour (
        .hour_in   (cur[IX_HOUR][6:0]),
        .hour_out  (hr_next),
        .day_carry (hr_carry)
    );

    rtc_date_step u_date (
        .dow_in     (cur[IX_DOW][2:0]),
        .date_in    (cur[IX_DATE][5:0]),
        .month_in   (cur[IX_MONTH][4:0]),
        .year_in    (cur[IX_YEAR]),
        .dow_out    (dow_n),
        .date_out   (date_n),
        .month_out  (month_n),
        .year_out   (year_n),
        .month_roll (month_roll)
    );

    always_comb begin
        sec_wrap = (cur[IX_SEC][6:0] == 7'h59);
        hour_adv = sec_wrap && (cur[IX_MIN][6:0] == 7'h59);
        day_roll = hour_adv && hr_carry;

        nxt[IX_SEC]   = sec_wrap ? {halted, 7'h00}
                                 : ({halted, 7'b0} | (bcd_inc({1'b0, cur[IX_SEC][6:0]}) & 8'h7F));
        if (!sec_wrap)
            nxt[IX_MIN] = cur[IX_MIN];
        else if (cur[IX_MIN][6:0] == 7'h59)
            nxt[IX_MIN] = 8'h00;
        else
            nxt[IX_MIN] = bcd_inc(cur[IX_MIN]) & 8'h7F;
        nxt[IX_HOUR]  = hour_adv ? hr_next : cur[IX_HOUR];
        nxt[IX_DOW]   = day_roll ? dow_n   : cur[IX_DOW];
        nxt[IX_DATE]  = day_roll ? date_n  : cur[IX_DATE];
        nxt[IX_MONTH] = day_roll ? month_n : cur[IX_MONTH];
        nxt[IX_YEAR]  = day_roll ? year_n  : cur[IX_YEAR];
    end

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= reset_value(i);
            else if (wr_en && wr_idx == IDX_W'(i))
                q <= wr_data & field_mask(i);
            else if (advance)
                q <= nxt[i];
        end
        assign cur[i] = q;
        assign live_flat[i*BYTE_W +: BYTE_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sec_written <= 1'b0;
        else
            sec_written <= wr_en && (wr_idx == IX_SEC);
    end

    rtc_snapshot u_snap (
        .clk       (clk),
        .rst       (rst),
        .capture   (snap_req),
        .live_flat (live_flat),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && cur[IX_SEC][6:0] == 7'h59 |=> cur[IX_SEC][6:0] == 7'h00 && cur[IX_MIN] != $past(cur[IX_MIN])); // R1
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted && !wr_en |=> $stable(cur[IX_SEC]) && $stable(cur[IX_MIN]) && $stable(cur[IX_HOUR])); // R2
    AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && hour_adv && cur[IX_HOUR] == 8'h23 |=> cur[IX_HOUR] == 8'h00); // R3
    AST_HOUR12_PM: assert property (@(posedge clk) disable iff (rst)
        advance && hour_adv && cur[IX_HOUR][6] && cur[IX_HOUR][4:0] == 5'h11 |=> cur[IX_HOUR][5] != $past(cur[IX_HOUR][5])); // R4
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && day_roll && cur[IX_DOW] == 8'h07 |=> cur[IX_DOW] == 8'h01); // R5
    AST_DATE_RESTART: assert property (@(posedge clk) disable iff (rst)
        advance && day_roll && month_roll |=> cur[IX_DATE] == 8'h01); // R6
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IX_MIN |=> cur[IX_MIN] == ($past(wr_data) & 8'h7F)); // R9
    AST_SECW_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IX_SEC |=> sec_written); // R10
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // start bytes sec,min,hour,dow,date,month,year then expected bytes after one tick
    localparam logic [111:0] VEC [NVEC] = '{
        112'h00_00_00_01_01_01_00_01_00_00_01_01_01_00, // R1 plain count
        112'h59_09_00_01_01_01_00_00_10_00_01_01_01_00, // R1 sec wrap, min digit carry
        112'h59_59_23_07_15_06_23_00_00_00_01_16_06_23, // R3 R5 midnight, dow 7->1
        112'h59_59_23_03_30_04_23_00_00_00_04_01_05_23, // R6 30-day month
        112'h59_59_23_02_28_02_23_00_00_00_03_01_03_23, // R6 Feb common year
        112'h59_59_23_02_28_02_24_00_00_00_03_29_02_24, // R6 Feb leap 28->29
        112'h59_59_23_05_31_12_99_00_00_00_06_01_01_00, // R6 year 99->00
        112'h59_59_51_01_10_03_05_00_00_72_01_10_03_05, // R4 11AM->12PM
        112'h59_59_71_02_10_03_05_00_00_52_03_11_03_05, // R4 11PM->12AM day carry
        112'h59_59_72_02_10_03_05_00_00_61_02_10_03_05, // R4 12PM->1PM
        112'h59_59_09_02_10_03_05_00_00_10_02_10_03_05, // R3 09->10
        112'h59_59_23_01_29_02_00_00_00_00_02_01_03_00, // R6 leap Feb 29 year 00
        112'h59_59_23_04_31_01_10_00_00_00_05_01_02_10  // R6 Jan 31
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       snap_req = 1'b0;
    logic [2:0] rd_idx = 3'd0;
    logic [7:0] rd_data;
    logic       sec_written;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_core u0 (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .snap_req(snap_req), .rd_idx(rd_idx), .rd_data(rd_data),
        .sec_written(sec_written)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] i, input logic [7:0] exp);
        rd_idx = i;
        #1;
        check($sformatf("%s idx%0d", tag, i), rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        rd_chk("R11 reset", 3'd0, 8'h00);
        rd_chk("R11 reset", 3'd2, 8'h00);
        rd_chk("R11 reset", 3'd3, 8'h01);
        rd_chk("R11 reset", 3'd4, 8'h01);
        rd_chk("R11 reset", 3'd5, 8'h01);
        rd_chk("R11 reset", 3'd6, 8'h00);
        check("R11 sec_written reset", {7'b0, sec_written}, 8'h00);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 7; k++)
                wr(3'(k), VEC[v][111-8*k -: 8]);
            tick();
            snap();
            for (int k = 0; k < 7; k++)
                rd_chk($sformatf("vector %0d (R1 R3 R4 R5 R6)", v), 3'(k), VEC[v][55-8*k -: 8]);
        end

        // R2 halt
        wr(3'd1, 8'h20);
        wr(3'd0, 8'h90);
        tick(); tick(); tick();
        snap();
        rd_chk("R2 halted sec", 3'd0, 8'h90);
        rd_chk("R2 halted min", 3'd1, 8'h20);
        wr(3'd0, 8'h10);
        tick();
        snap();
        rd_chk("R2 running sec", 3'd0, 8'h11);

        // R9 write beats a same-cycle tick
        wr(3'd0, 8'h59);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd1; wr_data = 8'h30; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        snap();
        rd_chk("R9 tick dropped sec", 3'd0, 8'h59);
        rd_chk("R9 write loaded min", 3'd1, 8'h30);

        // R7 masks and unused index
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd7, 8'hFF);
        snap();
        rd_chk("R7 min mask", 3'd1, 8'h7F);
        rd_chk("R7 hour mask", 3'd2, 8'h7F);
        rd_chk("R7 dow mask", 3'd3, 8'h07);
        rd_chk("R7 date mask", 3'd4, 8'h3F);
        rd_chk("R7 month mask", 3'd5, 8'h1F);
        rd_chk("R7 index 7", 3'd7, 8'h00);
        rd_chk("R7 sec untouched by index 7", 3'd0, 8'h59);

        // R8 snapshot coherence
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h01);
        wr(3'd4, 8'h01); wr(3'd5, 8'h01);
        wr(3'd0, 8'h40);
        snap();
        tick(); tick(); tick(); tick(); tick();
        rd_chk("R8 shadow holds", 3'd0, 8'h40);
        snap();
        rd_chk("R8 shadow updated", 3'd0, 8'h45);

        // R8 capture with a same-cycle tick takes the pre-edge value
        @(negedge clk);
        snap_req = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        snap_req = 1'b0; tick_1hz = 1'b0;
        rd_chk("R8 capture pre-tick", 3'd0, 8'h45);
        snap();
        rd_chk("R8 after tick", 3'd0, 8'h46);

        // R10 seconds write strobe
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 strobe after sec write", {7'b0, sec_written}, 8'h01);
        @(negedge clk);
        #1;
        check("R10 strobe one cycle", {7'b0, sec_written}, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 no strobe for min write", {7'b0, sec_written}, 8'h00);

        // R11 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R11 re-reset sec", 3'd0, 8'h00);
        rd_chk("R11 re-reset dow", 3'd3, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule